// File: doc/BRIEF.md
# Serial RAM Boot Loader Controller

This block is a hardware sequencer that runs once after reset and decides how the chip starts. A boot-select strap is sampled first. When the strap is high, the controller looks at the reset vector. An all-ones vector marks erased program storage, and the controller then parks in a halt state. Any other vector is handed on as the start address.

When the strap is low, the controller runs a code-update exchange with an external host over a byte-wide synchronous serial link. It announces itself with a sync token and waits a bounded time for the host's match token. It then reads a 16-bit byte count and pulls that many bytes into internal RAM from a fixed base address, sending a ready token before each byte. The first eight bytes of this image hold the interrupt vectors of the loaded program. A closing exchange ends the transfer. Every RAM byte outside the image is then set to FFh, and the controller hands over by pulsing done with an entry address 18h above the base.

The serial bit engine, the baud clock and the CPU are outside this block. The controller only sees byte handshakes, a RAM write port, the strap, the vector and its own status lines.

Top module: `sboot_ctrl`

## Requirements
- R1: While reset is held, tx_valid_o, ram_we_o, done_o, halted_o and error_o are all 0. After reset is released with the strap low, the first byte offered on the transmit side is 25h.
- R2: If the strap is high and the reset vector is FFFFh, halted_o rises and stays at 1 until the next reset. While halted, nothing is transmitted and nothing is written to RAM.
- R3: If the strap is high and the reset vector is any other value, done_o pulses for exactly one cycle with jump_addr_o equal to the vector, and busy_o is 0 afterwards. At most one of done_o, halted_o and error_o is high in any cycle.
- R4: After the sync byte, a received byte other than 23h is ignored and no new byte is offered. A received 23h leads to a 21h being offered. An offered byte keeps tx_valid_o high and tx_data_o unchanged until tx_ready_i accepts it.
- R5: If no 23h arrives within TMO_CYC cycles of the sync byte being accepted, the controller samples the strap again. A low strap sends 25h again; a high strap takes the normal start path.
- R6: The two length bytes that follow arrive most significant byte first. A length of 0, or a length above MAX_LEN, raises error_o and causes no RAM write.
- R7: Before each payload byte a 21h is offered. Payload byte k is written to RAM address BASE_ADDR + k.
- R8: After the last payload byte a further 21h is offered. A following received 25h is ignored. Any other received byte is taken as confirmation.
- R9: After confirmation, every RAM address outside the payload range is written exactly once with FFh, and no payload address is written again.
- R10: When the fill ends, done_o pulses for one cycle with jump_addr_o = BASE_ADDR + 18h, and busy_o then stays 0.
- R11: rx_err_i high at any point during the update exchange or the fill moves the controller to a state that holds until reset. In that state error_o is 1 and busy_o is 0, and no further RAM writes or transmit offers happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Boot select: 0 requests a code update |
| rst_vec_i | input | 16 | Reset vector read from program storage |
| tx_data_o | output | 8 | Byte offered to the serial transmitter |
| tx_valid_o | output | 1 | Transmit byte is valid |
| tx_ready_i | input | 1 | Transmitter accepts the offered byte |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | One-cycle strobe for a received byte |
| rx_err_i | input | 1 | Receive error from the serial interface |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | RAM_AW | RAM byte address |
| ram_wdata_o | output | 8 | RAM write data |
| busy_o | output | 1 | Sequence still running |
| done_o | output | 1 | One-cycle handover pulse |
| jump_addr_o | output | 16 | Start address, valid with done_o |
| halted_o | output | 1 | Erased storage with no update requested |
| error_o | output | 1 | Update abandoned on a bad length or receive error |

## Verification
The bench goes after these corner cases:
- It sends a stray byte while the controller waits for the match token. A design that accepts any byte there would answer early with 21h.
- It sends 25h as the closing byte. A design that takes it as confirmation would start the fill too soon.
- It sends the length 10h,01h. A design that reads it least significant byte first sees 272, a legal length, and would carry on instead of raising the error.
- It lets the match wait time out, once with the strap low and once with it raised. This catches a design that stalls, or one that never samples the strap again.
- It counts writes to every RAM address. A fill that skips the range edges, or writes over the image, shows up as a wrong count or a wrong value.

// File: rtl/sboot_pkg.sv
package sboot_pkg;
  localparam logic [7:0]  TOK_SYNC  = 8'h25;
  localparam logic [7:0]  TOK_MATCH = 8'h23;
  localparam logic [7:0]  TOK_READY = 8'h21;
  localparam logic [7:0]  FILL_BYTE = 8'hFF;
  localparam logic [15:0] BLANK_VEC = 16'hFFFF;
  localparam logic [15:0] ENTRY_OFS = 16'h0018;

  typedef enum logic [3:0] {
    S_BOOT, S_TX_SYNC, S_WAIT_MATCH, S_TX_ACK, S_LEN_HI, S_LEN_LO,
    S_TX_RDY, S_RX_BYTE, S_TX_END, S_WAIT_CONF, S_FILL, S_LAUNCH,
    S_FINISH, S_HALT, S_ERROR
  } boot_st_e;
endpackage

// File: rtl/sboot_tmo.sv
module sboot_tmo #(
  parameter int LIMIT = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign expired_o = (cnt_q == W'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)          cnt_d = '0;
    else if (!expired_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sboot_cnt.sv
module sboot_cnt #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign cnt_o = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sboot_ctrl.sv
module sboot_ctrl
  import sboot_pkg::*;
#(
  parameter int RAM_AW    = 13,
  parameter int BASE_ADDR = 16,
  parameter int MAX_LEN   = 4096,
  parameter int TMO_CYC   = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_i,
  input  logic [15:0]       rst_vec_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_err_i,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [15:0]       jump_addr_o,
  output logic              halted_o,
  output logic              error_o
);
  localparam int          LW         = $clog2(MAX_LEN + 1);
  localparam logic [16:0] BASE17     = 17'(BASE_ADDR);
  localparam logic [15:0] LOAD_ENTRY = 16'(BASE_ADDR) + ENTRY_OFS;
  localparam logic [15:0] LEN_CAP    = 16'(MAX_LEN);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  boot_st_e          st_q, st_d;
  logic [15:0]       len_q, len_d;
  logic [15:0]       jump_q, jump_d;
  logic              we_q, we_d;
  logic [RAM_AW-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;

  logic              tmo_hit;
  logic [LW-1:0]     idx_cnt;
  logic [RAM_AW-1:0] fill_cnt;
  logic              rx_hit, in_update, abort;
  logic              pay_we, fill_we, last_byte, fill_last, in_pay;
  logic [15:0]       len_full;
  logic [16:0]       fill17, pay_end17;

  sboot_tmo #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_ns),
    .run_i(st_q == S_WAIT_MATCH),
    .expired_o(tmo_hit)
  );

  sboot_cnt #(.W(LW)) u_idx (
    .clk(clk), .rst_n(rst_ns),
    .clr_i(st_q == S_LEN_LO),
    .inc_i(pay_we),
    .cnt_o(idx_cnt)
  );

  sboot_cnt #(.W(RAM_AW)) u_fill (
    .clk(clk), .rst_n(rst_ns),
    .clr_i(st_q != S_FILL),
    .inc_i(st_q == S_FILL),
    .cnt_o(fill_cnt)
  );

  assign rx_hit    = rx_valid_i && !rx_err_i;
  assign in_update = st_q inside {S_TX_SYNC, S_WAIT_MATCH, S_TX_ACK, S_LEN_HI,
                                  S_LEN_LO, S_TX_RDY, S_RX_BYTE, S_TX_END,
                                  S_WAIT_CONF, S_FILL};
  assign abort     = in_update && rx_err_i;
  assign len_full  = {len_q[15:8], rx_data_i};
  assign last_byte = (16'(idx_cnt) == (len_q - 16'd1));
  assign fill_last = (fill_cnt == {RAM_AW{1'b1}});
  assign fill17    = 17'(fill_cnt);
  assign pay_end17 = BASE17 + {1'b0, len_q};
  assign in_pay    = (fill17 >= BASE17) && (fill17 < pay_end17);
  assign pay_we    = (st_q == S_RX_BYTE) && rx_hit;
  assign fill_we   = (st_q == S_FILL) && !in_pay && !rx_err_i;

  // next-state process
  always_comb begin
    st_d   = st_q;
    len_d  = len_q;
    jump_d = jump_q;
    unique case (st_q)
      S_BOOT: begin
        if (!strap_i)                    st_d = S_TX_SYNC;
        else if (rst_vec_i == BLANK_VEC) st_d = S_HALT;
        else begin
          st_d   = S_LAUNCH;
          jump_d = rst_vec_i;
        end
      end
      S_TX_SYNC:    if (tx_ready_i) st_d = S_WAIT_MATCH;
      S_WAIT_MATCH: begin
        if (rx_hit && rx_data_i == TOK_MATCH) st_d = S_TX_ACK;
        else if (tmo_hit)                     st_d = S_BOOT;
      end
      S_TX_ACK:     if (tx_ready_i) st_d = S_LEN_HI;
      S_LEN_HI: begin
        if (rx_hit) begin
          len_d[15:8] = rx_data_i;
          st_d        = S_LEN_LO;
        end
      end
      S_LEN_LO: begin
        if (rx_hit) begin
          len_d = len_full;
          if (len_full == 16'd0 || len_full > LEN_CAP) st_d = S_ERROR;
          else                                         st_d = S_TX_RDY;
        end
      end
      S_TX_RDY:     if (tx_ready_i) st_d = S_RX_BYTE;
      S_RX_BYTE:    if (rx_hit) st_d = last_byte ? S_TX_END : S_TX_RDY;
      S_TX_END:     if (tx_ready_i) st_d = S_WAIT_CONF;
      S_WAIT_CONF: begin
        if (rx_hit && rx_data_i != TOK_SYNC) begin
          st_d   = S_FILL;
          jump_d = LOAD_ENTRY;
        end
      end
      S_FILL:       if (fill_last) st_d = S_LAUNCH;
      S_LAUNCH:     st_d = S_FINISH;
      S_FINISH:     st_d = S_FINISH;
      S_HALT:       st_d = S_HALT;
      S_ERROR:      st_d = S_ERROR;
      default:      st_d = S_ERROR;
    endcase
    if (abort) st_d = S_ERROR;
  end

  // RAM port next values
  always_comb begin
    we_d   = pay_we || fill_we;
    addr_d = addr_q;
    data_d = data_q;
    if (pay_we) begin
      addr_d = RAM_AW'(BASE17 + 17'(idx_cnt));
      data_d = rx_data_i;
    end else if (fill_we) begin
      addr_d = fill_cnt;
      data_d = FILL_BYTE;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= S_BOOT;
      len_q  <= '0;
      jump_q <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      len_q  <= len_d;
      jump_q <= jump_d;
      we_q   <= we_d;
      if (we_d) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  assign tx_valid_o  = st_q inside {S_TX_SYNC, S_TX_ACK, S_TX_RDY, S_TX_END};
  assign tx_data_o   = (st_q == S_TX_SYNC) ? TOK_SYNC : TOK_READY;
  assign ram_we_o    = we_q;
  assign ram_addr_o  = addr_q;
  assign ram_wdata_o = data_q;
  assign busy_o      = !(st_q inside {S_FINISH, S_HALT, S_ERROR});
  assign done_o      = (st_q == S_LAUNCH);
  assign jump_addr_o = jump_q;
  assign halted_o    = (st_q == S_HALT);
  assign error_o     = (st_q == S_ERROR);
endmodule

// File: rtl/sboot_chk.sv
module sboot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] tx_data_o,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic       ram_we_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       halted_o,
  input logic       error_o
);
  AST_HALT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o); // R2
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> (!tx_valid_o && !ram_we_o)); // R2
  AST_FLAG_EXCL:  assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halted_o, error_o, done_o})); // R3
  AST_TX_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R10
  AST_ERR_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> error_o); // R11
  AST_ERR_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (!ram_we_o && !tx_valid_o && !busy_o)); // R11
endmodule

bind sboot_ctrl sboot_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i), .ram_we_o(ram_we_o), .busy_o(busy_o),
  .done_o(done_o), .halted_o(halted_o), .error_o(error_o)
);

// File: tb/sboot_ctrl_tb_top.sv
module sboot_ctrl_tb_top;
  localparam int RAM_AW = 9;
  localparam int DEPTH  = 1 << RAM_AW;
  localparam int BASE   = 16;
  localparam int TMO    = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b1;
  logic [15:0] vec = 16'h1234;
  logic [7:0] tx_data;
  logic tx_valid;
  logic tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_valid = 1'b0;
  logic rx_err = 1'b0;
  logic ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [7:0] ram_wdata;
  logic busy, done, halted, error;
  logic [15:0] jump;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [7:0] mem [DEPTH];
  int wcnt [DEPTH];
  int wtotal = 0;

  always #10 clk = ~clk;

  sboot_ctrl #(.RAM_AW(RAM_AW), .BASE_ADDR(BASE), .MAX_LEN(4096), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .rst_vec_i(vec),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_err_i(rx_err),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .busy_o(busy), .done_o(done), .jump_addr_o(jump),
    .halted_o(halted), .error_o(error)
  );

  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      mem[ram_addr] <= ram_wdata;
      wcnt[ram_addr] <= wcnt[ram_addr] + 1;
      wtotal <= wtotal + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic s, input logic [15:0] v);
    rst_n = 1'b0;
    strap = s;
    vec = v;
    tx_ready = 1'b0;
    rx_valid = 1'b0;
    rx_err = 1'b0;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'h00;
      wcnt[i] = 0;
    end
    wtotal = 0;
    @(negedge clk);
    chk(!tx_valid && !ram_we && !done && !halted && !error, "R1 reset outputs quiet",
        {tx_valid, ram_we, done, halted, error}, 0);
    rst_n = 1'b1;
  endtask

  task automatic expect_tx(input logic [7:0] exp, input string tag);
    int w = 0;
    logic [7:0] first;
    while (!tx_valid && w < 3000) begin
      @(negedge clk);
      w++;
    end
    chk(tx_valid, {tag, " byte offered"}, tx_valid, 1);
    chk(tx_data == exp, tag, tx_data, exp);
    first = tx_data;
    repeat (2) @(negedge clk);
    chk(tx_valid && tx_data == first, "R4 offer held until accepted", tx_data, first);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    rx_data = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_done(output logic seen, input int lim);
    seen = 1'b0;
    for (int i = 0; i < lim && !seen; i++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic t_halt();
    do_reset(1'b1, 16'hFFFF);
    repeat (6) @(negedge clk);
    chk(halted && !busy, "R2 erased vector halts", halted, 1);
    repeat (20) @(negedge clk);
    chk(halted && !tx_valid && wtotal == 0, "R2 halt persists, nothing sent or written",
        wtotal, 0);
  endtask

  task automatic t_normal();
    logic seen;
    do_reset(1'b1, 16'h1234);
    wait_done(seen, 50);
    chk(seen, "R3 done pulse on normal start", seen, 1);
    chk(jump == 16'h1234, "R3 jump equals vector", jump, 16'h1234);
    @(negedge clk);
    chk(!done && !busy && !halted && !error, "R3 single pulse then idle", done, 0);
  endtask

  task automatic t_load();
    logic seen;
    logic [7:0] img [5];
    int errs;
    img[0] = 8'hA1; img[1] = 8'h00; img[2] = 8'hFF; img[3] = 8'h5C; img[4] = 8'h25;
    do_reset(1'b0, 16'hFFFF);
    expect_tx(8'h25, "R1 first byte is sync");
    send_rx(8'h55);
    repeat (6) @(negedge clk);
    chk(!tx_valid, "R4 stray byte ignored while waiting for match", tx_valid, 0);
    send_rx(8'h23);
    expect_tx(8'h21, "R4 ack after match");
    send_rx(8'h00);
    send_rx(8'h05);
    for (int k = 0; k < 5; k++) begin
      expect_tx(8'h21, "R7 ready before payload byte");
      send_rx(img[k]);
    end
    expect_tx(8'h21, "R8 end request");
    send_rx(8'h25);
    repeat (8) @(negedge clk);
    chk(busy && !done && wtotal == 5, "R8 confirmation byte 25h ignored", wtotal, 5);
    send_rx(8'h00);
    wait_done(seen, 3000);
    chk(seen, "R10 done after fill", seen, 1);
    chk(jump == 16'(BASE + 8'h18), "R10 jump to base plus 18h", jump, BASE + 8'h18);
    @(negedge clk);
    chk(!done && !busy, "R10 idle after handover", busy, 0);
    errs = 0;
    for (int k = 0; k < 5; k++)
      if (mem[BASE + k] != img[k] || wcnt[BASE + k] != 1) errs++;
    chk(errs == 0, "R7 payload at consecutive addresses", errs, 0);
    errs = 0;
    for (int a = 0; a < DEPTH; a++)
      if ((a < BASE || a >= BASE + 5) && (mem[a] != 8'hFF || wcnt[a] != 1)) errs++;
    chk(errs == 0, "R9 every unused address written once with FFh", errs, 0);
    chk(wtotal == DEPTH, "R9 total writes", wtotal, DEPTH);
  endtask

  task automatic t_timeout();
    logic seen;
    do_reset(1'b0, 16'hABCD);
    expect_tx(8'h25, "R5 sync");
    repeat (TMO + 10) @(negedge clk);
    expect_tx(8'h25, "R5 sync resent after timeout with strap low");
    strap = 1'b1;
    wait_done(seen, TMO + 50);
    chk(seen && jump == 16'hABCD, "R5 normal path after timeout with strap high",
        jump, 16'hABCD);
  endtask

  task automatic t_len(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    do_reset(1'b0, 16'h0000);
    expect_tx(8'h25, "R1 sync");
    send_rx(8'h23);
    expect_tx(8'h21, "R4 ack");
    send_rx(hi);
    send_rx(lo);
    @(negedge clk);
    chk(error && !busy, tag, error, 1);
    repeat (10) @(negedge clk);
    chk(error && wtotal == 0 && !tx_valid, "R6 no writes after bad length", wtotal, 0);
  endtask

  task automatic t_rxerr();
    do_reset(1'b0, 16'h0000);
    expect_tx(8'h25, "R1 sync");
    send_rx(8'h23);
    expect_tx(8'h21, "R4 ack");
    send_rx(8'h00);
    send_rx(8'h04);
    expect_tx(8'h21, "R7 ready");
    send_rx(8'h77);
    expect_tx(8'h21, "R7 ready");
    rx_err = 1'b1;
    @(negedge clk);
    rx_err = 1'b0;
    chk(error && !busy, "R11 receive error aborts", error, 1);
    send_rx(8'h66);
    repeat (10) @(negedge clk);
    chk(error && wtotal == 1 && !tx_valid, "R11 no activity after abort", wtotal, 1);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    t_halt();
    t_normal();
    t_load();
    t_timeout();
    t_len(8'h00, 8'h00, "R6 zero length rejected");
    t_len(8'h10, 8'h01, "R6 length 4097 rejected, MSB first");
    t_rxerr();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule